// File: doc/BRIEF.md
# ATAPI PIO Packet Read Sequencer

This block is the device end of a packet-command exchange carried out with programmed I/O. The host writes a 16-bit byte-count limit into two taskfile registers and then issues the packet command. The block raises DRQ and takes a 12-byte command packet as six 16-bit writes to the data register. It then decodes the packet. Only READ(10) is supported, and it is served from a block-memory read port of 16-bit words with 2048-byte logical blocks.

Data leaves through the 16-bit data register in bursts. Before each burst the block raises its interrupt and writes the size of that burst back into the byte-count registers. The block holds BSY between the phases. After the last word it raises one last interrupt and returns to DRDY alone. A host read of the status register clears the interrupt.

Top module: `atapiPioSeq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40 (DRDY only), the error register (address 1) reads 0x00 and `irq` is low. Status bit positions are BSY=0x80, DRDY=0x40, DF=0x20, DRQ=0x08 and ERR=0x01.
- R2: Writing 0xA0 to address 7 while idle makes the status read 0x48 (DRQ|DRDY) on the next cycle. In the same write the byte-count limit is captured: address 4 supplies the low byte and address 5 the high byte. The write also clears any earlier ERR.
- R3: The packet arrives as six writes to address 0. Write k carries packet byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Byte 0 equal to 0x28 selects READ(10). Bytes 2 to 5 hold the start block (most significant byte first) and bytes 7 to 8 hold the block count (most significant byte first). The n-th data word read is taken from memory word address start*1024+n.
- R4: Status reads 0xC0 (BSY|DRDY, no DRQ) for at least one cycle after the sixth packet word and after the last word of every burst that is not the final one.
- R5: Every burst carries the remaining byte count when that count is below the limit. Otherwise it carries the limit with bit 0 cleared. The burst size can be read back at address 4 (low byte) and address 5 (high byte) while the burst is pending.
- R6: At the start of each burst `irq` rises and the status reads 0x48. A read of address 7 while BSY is clear lowers `irq` on the next cycle.
- R7: The read of the last data word raises `irq` again, and the status reads 0x40.
- R8: A packet whose byte 0 is not 0x28 ends the command. The status then reads 0x41, the error register reads 0x04 (abort) and `irq` is raised.
- R9: A byte-count limit of 0 or 1 ends the command in the same way as R8: status 0x41, error 0x04 and `irq` raised.
- R10: A READ(10) packet with a block count of zero completes with `irq` and status 0x40, and no data phase takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regRdEn | input | 1 | Host register read strobe (reads of addresses 0 and 7 have side effects) |
| regAddr | input | 3 | Taskfile register address |
| regWrData | input | 16 | Host write data |
| regRdData | output | 16 | Register read data for `regAddr` (combinational) |
| irq | output | 1 | Interrupt request to host |
| memAddr | output | ADDR_W | Block-memory word address |
| memRdEn | output | 1 | Asserted in the cycle a data word is consumed |
| memRdData | input | 16 | Word at `memAddr`, valid in the same cycle |

## Verification
The sequencer state is visible at the ports through the status byte and the interrupt. A stuck or skipped state shows up as a wrong status value, or as a missing or extra `irq`, in the very next cycle. That value can be read through a peek of address 7, which has no side effect. A miscounted burst or remainder is caught at the burst boundary. There the byte-count readback, the BSY gap and the word stream read from memory must all agree with sizes computed from the limit. An address error shows as a wrong data word on the first word read after the fault.

// File: rtl/atapiSeqPkg.sv
package atapiSeqPkg;
  localparam logic [7:0] ST_BSY  = 8'h80;
  localparam logic [7:0] ST_DRDY = 8'h40;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] ST_ERR  = 8'h01;
  localparam logic [7:0] ERR_ABORT = 8'h04;
  localparam logic [7:0] CMD_PACKET = 8'hA0;
  localparam logic [7:0] OP_READ10  = 8'h28;

  typedef enum logic [2:0] {
    S_IDLE, S_PKT, S_CHECK, S_PREP, S_XFER
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrBcLo;
    logic wrBcHi;
    logic latchLimit;
    logic capWord;
    logic loadXfer;
    logic loadBurst;
    logic popWord;
  } dpCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic pktLast;
    logic cmdOk;
    logic limitBad;
    logic countZero;
    logic burstLast;
    logic remLast;
  } dpFlags_t;
endpackage

// File: rtl/atapiSeqDatapath.sv
module atapiSeqDatapath
  import atapiSeqPkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BLOCK_BYTES = 2048,
  parameter int PKT_WORDS   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [15:0]       wrData,
  output dpFlags_t          flags,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        bcLo,
  output logic [7:0]        bcHi
);
  localparam int LOG_BB = $clog2(BLOCK_BYTES);
  localparam int WSH    = LOG_BB - 1;
  localparam int REM_W  = 16 + LOG_BB;
  localparam int IDX_W  = $clog2(PKT_WORDS);

  logic [IDX_W-1:0]  pktIdx;
  logic [7:0]        opcode;
  logic [31:0]       startBlk;
  logic [15:0]       blkCount;
  logic [15:0]       limitQ;
  logic [REM_W-1:0]  remBytes;
  logic [14:0]       burstWords;
  logic [ADDR_W-1:0] wordPtr;
  logic [15:0]       burstBytes;
  logic [15:0]       limitEven;

  assign limitEven = {limitQ[15:1], 1'b0};

  always_comb begin
    if (remBytes < REM_W'(limitQ)) burstBytes = remBytes[15:0];
    else                           burstBytes = limitEven;
  end

  // packet capture: only the fields READ(10) needs are kept
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktIdx   <= '0;
      opcode   <= '0;
      startBlk <= '0;
      blkCount <= '0;
    end else if (ctl.latchLimit) begin
      pktIdx <= '0;
    end else if (ctl.capWord) begin
      pktIdx <= pktIdx + 1'b1;
      case (pktIdx)
        IDX_W'(0): opcode         <= wrData[7:0];
        IDX_W'(1): startBlk[31:16] <= {wrData[7:0], wrData[15:8]};
        IDX_W'(2): startBlk[15:0]  <= {wrData[7:0], wrData[15:8]};
        IDX_W'(3): blkCount[15:8]  <= wrData[15:8];
        IDX_W'(4): blkCount[7:0]   <= wrData[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bcLo <= '0;
      bcHi <= '0;
      limitQ <= '0;
      remBytes <= '0;
      burstWords <= '0;
      wordPtr <= '0;
    end else begin
      if (ctl.wrBcLo) bcLo <= wrData[7:0];
      if (ctl.wrBcHi) bcHi <= wrData[7:0];
      if (ctl.latchLimit) limitQ <= {bcHi, bcLo};
      if (ctl.loadXfer) begin
        remBytes <= REM_W'({blkCount, {LOG_BB{1'b0}}});
        wordPtr  <= ADDR_W'({startBlk, {WSH{1'b0}}});
      end
      if (ctl.loadBurst) begin
        burstWords <= burstBytes[15:1];
        {bcHi, bcLo} <= burstBytes;
      end
      if (ctl.popWord) begin
        burstWords <= burstWords - 1'b1;
        remBytes   <= remBytes - REM_W'(2);
        wordPtr    <= wordPtr + 1'b1;
      end
    end
  end

  assign memAddr         = wordPtr;
  assign flags.pktLast   = (pktIdx == IDX_W'(PKT_WORDS - 1));
  assign flags.cmdOk     = (opcode == OP_READ10);
  assign flags.limitBad  = (limitQ[15:1] == '0);
  assign flags.countZero = (blkCount == '0);
  assign flags.burstLast = (burstWords == 15'd1);
  assign flags.remLast   = (remBytes == REM_W'(2));
endmodule

// File: rtl/atapiSeqControl.sv
module atapiSeqControl
  import atapiSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] wrByte,
  input  dpFlags_t   flags,
  output dpCtrl_t    ctl,
  output logic [7:0] statusByte,
  output logic [7:0] errByte,
  output logic       irq,
  output logic       inXfer
);
  seqState_t state;
  logic errBit;
  logic cmdWr, dataWr, dataRd, statRd, abortNow, irqSet, irqClr;

  assign cmdWr  = regWrEn && (regAddr == 3'd7);
  assign dataWr = regWrEn && (regAddr == 3'd0);
  assign dataRd = regRdEn && (regAddr == 3'd0);
  assign statRd = regRdEn && (regAddr == 3'd7);
  assign abortNow = flags.limitBad || !flags.cmdOk;

  always_comb begin
    ctl = '0;
    ctl.wrBcLo     = (state == S_IDLE) && regWrEn && (regAddr == 3'd4);
    ctl.wrBcHi     = (state == S_IDLE) && regWrEn && (regAddr == 3'd5);
    ctl.latchLimit = (state == S_IDLE) && cmdWr && (wrByte == CMD_PACKET);
    ctl.capWord    = (state == S_PKT) && dataWr;
    ctl.loadXfer   = (state == S_CHECK) && !abortNow && !flags.countZero;
    ctl.loadBurst  = (state == S_PREP);
    ctl.popWord    = (state == S_XFER) && dataRd;
  end

  assign irqSet = ((state == S_CHECK) && (abortNow || flags.countZero))
               || (state == S_PREP)
               || (ctl.popWord && flags.remLast);
  assign irqClr = statRd || ctl.latchLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      errBit <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (irqSet)      irq <= 1'b1;
      else if (irqClr) irq <= 1'b0;
      case (state)
        S_IDLE:  if (ctl.latchLimit) begin
                   state  <= S_PKT;
                   errBit <= 1'b0;
                 end
        S_PKT:   if (ctl.capWord && flags.pktLast) state <= S_CHECK;
        S_CHECK: if (abortNow) begin
                   errBit <= 1'b1;
                   state  <= S_IDLE;
                 end else if (flags.countZero) state <= S_IDLE;
                 else state <= S_PREP;
        S_PREP:  state <= S_XFER;
        S_XFER:  if (ctl.popWord) begin
                   if (flags.remLast)        state <= S_IDLE;
                   else if (flags.burstLast) state <= S_PREP;
                 end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign inXfer  = (state == S_XFER);
  assign errByte = errBit ? ERR_ABORT : 8'h00;
  assign statusByte = ST_DRDY
                    | (((state == S_CHECK) || (state == S_PREP)) ? ST_BSY : 8'h00)
                    | (((state == S_PKT) || (state == S_XFER)) ? ST_DRQ : 8'h00)
                    | (errBit ? ST_ERR : 8'h00);
endmodule

// File: rtl/atapiPioSeq.sv
module atapiPioSeq
  import atapiSeqPkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BLOCK_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              irq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [15:0]       memRdData
);
  dpCtrl_t  ctl;
  dpFlags_t flags;
  logic [7:0] statusByte, errByte, bcLo, bcHi;
  logic inXfer;

  atapiSeqControl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .wrByte(regWrData[7:0]), .flags(flags), .ctl(ctl),
    .statusByte(statusByte), .errByte(errByte), .irq(irq), .inXfer(inXfer)
  );

  atapiSeqDatapath #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(regWrData), .flags(flags),
    .memAddr(memAddr), .bcLo(bcLo), .bcHi(bcHi)
  );

  assign memRdEn = ctl.popWord;

  always_comb begin
    case (regAddr)
      3'd0:    regRdData = inXfer ? memRdData : 16'h0000;
      3'd1:    regRdData = {8'h00, errByte};
      3'd4:    regRdData = {8'h00, bcLo};
      3'd5:    regRdData = {8'h00, bcHi};
      3'd7:    regRdData = {8'h00, statusByte};
      default: regRdData = 16'h0000;
    endcase
  end
endmodule

// File: rtl/atapiPioSeq_chk.sv
module atapiPioSeq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [2:0]        regAddr,
  input logic [15:0]       regWrData,
  input logic              irq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdEn,
  input logic [7:0]        statusByte
);
  p_pkt_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd7 && regWrData == 16'h00A0 && !statusByte[7] && !statusByte[3])
      |=> (statusByte == 8'h48));

  p_bsy_drq_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[7] && statusByte[3]));

  p_bsy_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[3]) |-> ($past(statusByte[7]) || $past(regWrEn && regAddr == 3'd7)));

  p_burst_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusByte[3]) && $past(statusByte[7])) |-> irq);

  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 3'd7 && !statusByte[7]) |=> !irq);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (memAddr == $past(memAddr) + 1'b1));
endmodule

bind atapiPioSeq atapiPioSeq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/atapiPioSeq_tb.sv
module atapiPioSeq_tb;
  localparam int ADDR_W = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic irq;
  logic [ADDR_W-1:0] memAddr;
  logic memRdEn;
  logic [15:0] memRdData;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] expWord(input int unsigned a);
    logic [ADDR_W-1:0] w;
    w = ADDR_W'(a);
    return 16'(w[15:0] * 16'd3 + 16'h1234);
  endfunction

  assign memRdData = expWord(int'(memAddr));

  atapiPioSeq #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irq(irq), .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic hostRd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // combinational look without a read strobe
  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIrq(input string req);
    int n = 0;
    while (!irq && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(req, "irq raised", int'(irq), 1);
  endtask

  task automatic sendPacket(input logic [7:0] op, input logic [31:0] blk, input logic [15:0] cnt);
    hostWr(3'd0, {8'h00, op});
    hostWr(3'd0, {blk[23:16], blk[31:24]});
    hostWr(3'd0, {blk[7:0], blk[15:8]});
    hostWr(3'd0, {cnt[15:8], 8'h00});
    hostWr(3'd0, {8'h00, cnt[7:0]});
    hostWr(3'd0, 16'h0000);
  endtask

  task automatic startCmd(input logic [15:0] limit, input string req);
    logic [15:0] s;
    hostWr(3'd4, {8'h00, limit[7:0]});
    hostWr(3'd5, {8'h00, limit[15:8]});
    hostWr(3'd7, 16'h00A0);
    peek(3'd7, s);
    check(req, "status after packet command", int'(s), 'h48);
  endtask

  task automatic testReset();
    logic [15:0] s;
    peek(3'd7, s);
    check("R1", "reset status", int'(s), 'h40);
    peek(3'd1, s);
    check("R1", "reset error", int'(s), 0);
    check("R1", "reset irq", int'(irq), 0);
  endtask

  task automatic testRead(input logic [31:0] blk, input int cnt, input int limit);
    logic [15:0] s;
    int rem = cnt * 2048;
    int idx = 0;
    int bad;
    int burst;
    startCmd(16'(limit), "R2");
    sendPacket(8'h28, blk, 16'(cnt));
    peek(3'd7, s);
    check("R4", "busy after packet", int'(s), 'hC0);
    while (rem > 0) begin
      burst = (rem < limit) ? rem : (limit & ~1);
      waitIrq("R6");
      hostRd(3'd7, s);
      check("R6", "status at burst start", int'(s), 'h48);
      check("R6", "irq after status read", int'(irq), 0);
      hostRd(3'd4, s);
      check("R5", "burst size low", int'(s), burst & 'hFF);
      hostRd(3'd5, s);
      check("R5", "burst size high", int'(s), (burst >> 8) & 'hFF);
      bad = 0;
      for (int w = 0; w < burst / 2; w++) begin
        hostRd(3'd0, s);
        if (s !== expWord(blk * 1024 + idx)) bad++;
        idx++;
      end
      check("R3", "mismatched data words in burst", bad, 0);
      rem -= burst;
      if (rem > 0) begin
        peek(3'd7, s);
        check("R4", "busy between bursts", int'(s), 'hC0);
      end
    end
    check("R7", "completion irq", int'(irq), 1);
    hostRd(3'd7, s);
    check("R7", "status after completion", int'(s), 'h40);
  endtask

  task automatic testAbort(input logic [7:0] op, input int limit, input string req);
    logic [15:0] s;
    startCmd(16'(limit), "R2");
    sendPacket(op, 32'd0, 16'd1);
    waitIrq(req);
    hostRd(3'd1, s);
    check(req, "abort error code", int'(s), 'h04);
    hostRd(3'd7, s);
    check(req, "abort status", int'(s), 'h41);
  endtask

  task automatic testZeroCount();
    logic [15:0] s;
    startCmd(16'd512, "R2");
    sendPacket(8'h28, 32'd3, 16'd0);
    waitIrq("R10");
    hostRd(3'd7, s);
    check("R10", "status with zero blocks", int'(s), 'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRead(32'd0, 1, 5120);
    testAbort(8'h12, 5120, "R8");
    testAbort(8'h28, 0, "R9");
    testAbort(8'h28, 1, "R9");
    testRead(32'd7, 3, 5121);
    testRead(32'd2, 1, 2001);
    testZeroCount();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule